// File: doc/BRIEF.md
# Boot Memory Chip-Select Decoder with Reset Overlay

This block turns processor bus cycles on a 32-bit address bus into chip selects for two byte-wide boot memory sockets. Reset leaves it in an overlay mode in which almost every access goes to boot memory, so the processor can fetch its reset vectors from there whatever address it issues. A single-cycle strobe from the boot code ends the overlay. From then on, boot memory answers only inside a fixed 1 MB window at the top of the address space.

A strap input chooses how the two sockets share that window. In the split arrangement, each socket gets one 512 KB half. In the single arrangement, the secondary socket fills the whole window and the primary socket is never used. A write-protect input blocks writes, and a blocked write ends in a bus error. Every accepted cycle ends with a byte-port acknowledge after a parameterised wait that covers the device access time. The block also forwards the programming-voltage enable to the primary socket only.

Top module: `bootrom_decode`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `cs_prim_n_o`, `cs_sec_n_o`, `we_n_o`, `ack8_n_o` and `berr_n_o` are all 1, and the overlay is active.
- R2: In overlay mode, a cycle whose function code is not 3'b111 selects boot memory at any address, except inside the controller register window `REG_BASE` to `REG_BASE + 2**REG_LOG2 - 1` (default 0xFFD0_0000 to 0xFFD0_0FFF). A cycle inside that window selects nothing.
- R3: After a one-cycle pulse on `boot_done_i`, the overlay ends from the next cycle on. Only reset brings it back, and further pulses change nothing.
- R4: After the overlay ends, only addresses 0xFFE0_0000 to 0xFFEF_FFFF select boot memory. Any other address leaves both chip selects at 1.
- R5: With `map_sel_i` = 0, address bit 19 picks the socket: 0 selects the primary socket and 1 selects the secondary. `rom_addr_o` is address bits 18:0 with bit 19 forced to 0. At most one chip select is low at any time.
- R6: With `map_sel_i` = 1, only the secondary socket is ever selected, and `rom_addr_o` is address bits 19:0.
- R7: A cycle with function code 3'b111 never asserts a chip select, a write enable, an acknowledge or a bus error.
- R8: On a selected cycle, the chip select (and `we_n_o` = 0 for a write, `rw_i` = 0) goes low on the first clock edge that samples `as_n_i` low. `ack8_n_o` goes low `WAIT_CYC` edges later, where `WAIT_CYC` = ceil(`ACCESS_NS` / `CLK_NS`) (20 by default). All outputs return to 1 on the edge that samples `as_n_i` high.
- R9: When `wp_i` = 1, a write to boot memory asserts no chip select and no write enable. `berr_n_o` goes low on the first edge instead, and no acknowledge follows. When `wp_i` = 0, the write proceeds. A read is never affected by `wp_i`.
- R10: `vpp_prim_n_o` follows `prog_volt_n_i` one cycle later when `map_sel_i` = 0, and is held at 1 (voltage off) when `map_sel_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 32 | Bus address |
| fc_i | input | 3 | Function code; 3'b111 is CPU space |
| rw_i | input | 1 | 1 = read, 0 = write |
| as_n_i | input | 1 | Address strobe, active low |
| map_sel_i | input | 1 | Socket mapping strap |
| wp_i | input | 1 | Write protect, 1 = protected |
| boot_done_i | input | 1 | One-cycle strobe that ends the overlay |
| prog_volt_n_i | input | 1 | Programming-voltage enable from a register bit, 0 = on |
| cs_prim_n_o | output | 1 | Primary socket chip select, active low |
| cs_sec_n_o | output | 1 | Secondary socket chip select, active low |
| we_n_o | output | 1 | Write enable to the sockets, active low |
| ack8_n_o | output | 1 | Byte-port acknowledge, active low |
| berr_n_o | output | 1 | Bus error, active low |
| rom_addr_o | output | 20 | Device byte address |
| vpp_prim_n_o | output | 1 | Programming-voltage enable for the primary socket, 0 = on |

## Verification
The decoder's results arrive at fixed distances from the edge that first samples the strobe low. Chip select, write enable, device address and bus error settle on that edge, the acknowledge follows exactly `WAIT_CYC` edges later, and release comes one edge after the strobe rises. For each access, the driver records three expected snapshots: one the cycle before the acknowledge is due, one on the cycle it is due, and one after release. The monitor compares each snapshot at the falling clock edge that matches its position, so an acknowledge that comes one cycle early or one cycle late is caught. The programming-voltage output lags its input by one register, and it is sampled one falling edge after the input changes.

// File: rtl/bootrom_pkg.sv
package bootrom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACK,
    ST_BERR,
    ST_SKIP
  } cyc_state_e;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/bootrom_overlay.sv
module bootrom_overlay (
  input  logic clk,
  input  logic rst,
  input  logic boot_done_i,
  output logic booted_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      booted_o <= 1'b0;
    end else if (boot_done_i) begin
      booted_o <= 1'b1;
    end
  end

endmodule

// File: rtl/bootrom_addr_map.sv
module bootrom_addr_map #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'hFFE0_0000,
  parameter int          WIN_LOG2 = 20,
  parameter logic [31:0] REG_BASE = 32'hFFD0_0000,
  parameter int          REG_LOG2 = 12
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2:0]          fc_i,
  input  logic                booted_i,
  input  logic                map_sel_i,
  output logic                hit_o,
  output logic                sec_o,
  output logic [WIN_LOG2-1:0] rom_addr_o
);

  localparam int HALF_BIT = WIN_LOG2 - 1;

  logic in_win;
  logic in_reg;
  logic cpu_space;

  assign cpu_space = (fc_i == 3'b111);
  assign in_win    = (addr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign in_reg    = (addr_i[ADDR_W-1:REG_LOG2] == REG_BASE[ADDR_W-1:REG_LOG2]);

  always_comb begin
    if (cpu_space) begin
      hit_o = 1'b0;
    end else if (booted_i) begin
      hit_o = in_win;
    end else begin
      hit_o = !in_reg;
    end
  end

  assign sec_o = map_sel_i | addr_i[HALF_BIT];

  always_comb begin
    rom_addr_o = addr_i[WIN_LOG2-1:0];
    if (!map_sel_i) begin
      rom_addr_o[HALF_BIT] = 1'b0;
    end
  end

endmodule

// File: rtl/bootrom_cycle_ctl.sv
module bootrom_cycle_ctl
  import bootrom_pkg::*;
#(
  parameter int WAIT_CYC = 20,
  parameter int RA_W     = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            as_n_i,
  input  logic            rw_i,
  input  logic            wp_i,
  input  logic            hit_i,
  input  logic            sec_i,
  input  logic [RA_W-1:0] rom_addr_i,
  output logic            cs_prim_n_o,
  output logic            cs_sec_n_o,
  output logic            we_n_o,
  output logic            ack8_n_o,
  output logic            berr_n_o,
  output logic [RA_W-1:0] rom_addr_o
);

  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC);

  cyc_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      cs_prim_n_o <= 1'b1;
      cs_sec_n_o  <= 1'b1;
      we_n_o      <= 1'b1;
      ack8_n_o    <= 1'b1;
      berr_n_o    <= 1'b1;
      rom_addr_o  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!as_n_i) begin
            if (!hit_i) begin
              state <= ST_SKIP;
            end else if (!rw_i && wp_i) begin
              berr_n_o <= 1'b0;
              state    <= ST_BERR;
            end else begin
              cs_prim_n_o <= sec_i;
              cs_sec_n_o  <= !sec_i;
              we_n_o      <= rw_i;
              rom_addr_o  <= rom_addr_i;
              cnt         <= CNT_W'(1);
              state       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (as_n_i) begin
            cs_prim_n_o <= 1'b1;
            cs_sec_n_o  <= 1'b1;
            we_n_o      <= 1'b1;
            state       <= ST_IDLE;
          end else if (cnt == CNT_LAST) begin
            ack8_n_o <= 1'b0;
            state    <= ST_ACK;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_ACK, ST_BERR, ST_SKIP: begin
          if (as_n_i) begin
            cs_prim_n_o <= 1'b1;
            cs_sec_n_o  <= 1'b1;
            we_n_o      <= 1'b1;
            ack8_n_o    <= 1'b1;
            berr_n_o    <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bootrom_decode.sv
module bootrom_decode
  import bootrom_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] WIN_BASE  = 32'hFFE0_0000,
  parameter int          WIN_LOG2  = 20,
  parameter logic [31:0] REG_BASE  = 32'hFFD0_0000,
  parameter int          REG_LOG2  = 12,
  parameter int          CLK_NS    = 10,
  parameter int          ACCESS_NS = 200
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2:0]          fc_i,
  input  logic                rw_i,
  input  logic                as_n_i,
  input  logic                map_sel_i,
  input  logic                wp_i,
  input  logic                boot_done_i,
  input  logic                prog_volt_n_i,
  output logic                cs_prim_n_o,
  output logic                cs_sec_n_o,
  output logic                we_n_o,
  output logic                ack8_n_o,
  output logic                berr_n_o,
  output logic [WIN_LOG2-1:0] rom_addr_o,
  output logic                vpp_prim_n_o
);

  localparam int WAIT_CYC = ceil_div(ACCESS_NS, CLK_NS);

  logic                booted;
  logic                hit;
  logic                sec;
  logic [WIN_LOG2-1:0] map_addr;

  bootrom_overlay u_overlay (
    .clk         (clk),
    .rst         (rst),
    .boot_done_i (boot_done_i),
    .booted_o    (booted)
  );

  bootrom_addr_map #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_LOG2 (WIN_LOG2),
    .REG_BASE (REG_BASE),
    .REG_LOG2 (REG_LOG2)
  ) u_map (
    .addr_i     (addr_i),
    .fc_i       (fc_i),
    .booted_i   (booted),
    .map_sel_i  (map_sel_i),
    .hit_o      (hit),
    .sec_o      (sec),
    .rom_addr_o (map_addr)
  );

  bootrom_cycle_ctl #(
    .WAIT_CYC (WAIT_CYC),
    .RA_W     (WIN_LOG2)
  ) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .as_n_i      (as_n_i),
    .rw_i        (rw_i),
    .wp_i        (wp_i),
    .hit_i       (hit),
    .sec_i       (sec),
    .rom_addr_i  (map_addr),
    .cs_prim_n_o (cs_prim_n_o),
    .cs_sec_n_o  (cs_sec_n_o),
    .we_n_o      (we_n_o),
    .ack8_n_o    (ack8_n_o),
    .berr_n_o    (berr_n_o),
    .rom_addr_o  (rom_addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vpp_prim_n_o <= 1'b1;
    end else begin
      vpp_prim_n_o <= prog_volt_n_i | map_sel_i;
    end
  end

endmodule

// File: rtl/bootrom_decode_chk.sv
module bootrom_decode_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] fc_i,
  input logic       rw_i,
  input logic       as_n_i,
  input logic       map_sel_i,
  input logic       wp_i,
  input logic       cs_prim_n_o,
  input logic       cs_sec_n_o,
  input logic       we_n_o,
  input logic       ack8_n_o,
  input logic       berr_n_o,
  input logic       vpp_prim_n_o
);

  AST_ONE_SOCKET: assert property (@(posedge clk) disable iff (rst)
    !(!cs_prim_n_o && !cs_sec_n_o)); // R5

  AST_MAP1_NO_PRIM: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_prim_n_o) |-> !$past(map_sel_i)); // R6

  AST_CPU_SPACE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_prim_n_o) || $fell(cs_sec_n_o) || $fell(berr_n_o)) |-> ($past(fc_i) != 3'b111)); // R7

  AST_RELEASE_ON_AS: assert property (@(posedge clk) disable iff (rst)
    (!ack8_n_o && as_n_i) |=> ack8_n_o); // R8

  AST_ACK_WITH_CS: assert property (@(posedge clk) disable iff (rst)
    $fell(ack8_n_o) |-> (!cs_prim_n_o || !cs_sec_n_o)); // R8

  AST_WP_NO_WE: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n_o) |-> !$past(wp_i)); // R9

  AST_BERR_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(berr_n_o) |-> !$past(rw_i)); // R9

  AST_NO_ACK_AND_BERR: assert property (@(posedge clk) disable iff (rst)
    !(!ack8_n_o && !berr_n_o)); // R9

  AST_VPP_OFF_MAP1: assert property (@(posedge clk) disable iff (rst)
    map_sel_i |=> vpp_prim_n_o); // R10

endmodule

bind bootrom_decode bootrom_decode_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .fc_i         (fc_i),
  .rw_i         (rw_i),
  .as_n_i       (as_n_i),
  .map_sel_i    (map_sel_i),
  .wp_i         (wp_i),
  .cs_prim_n_o  (cs_prim_n_o),
  .cs_sec_n_o   (cs_sec_n_o),
  .we_n_o       (we_n_o),
  .ack8_n_o     (ack8_n_o),
  .berr_n_o     (berr_n_o),
  .vpp_prim_n_o (vpp_prim_n_o)
);

// File: tb/bootrom_decode_tb_top.sv
module bootrom_decode_tb_top;

  localparam int WAIT = (200 + 10 - 1) / 10;

  typedef struct packed {
    logic        cp;
    logic        cs;
    logic        we;
    logic        ack;
    logic        berr;
    logic        chk_rom;
    logic [19:0] rom;
  } snap_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr = '0;
  logic [2:0]  fc = 3'b101;
  logic        rw = 1'b1;
  logic        as_n = 1'b1;
  logic        map_sel = 1'b0;
  logic        wp = 1'b0;
  logic        boot_done = 1'b0;
  logic        pv_n = 1'b1;
  logic        cs_prim_n, cs_sec_n, we_n, ack8_n, berr_n, vpp_n;
  logic [19:0] rom_addr;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    booted_m = 1'b0;
  snap_t exp_q[$];
  string tag_q[$];
  event  smp_ev;

  always #5 clk = ~clk;

  bootrom_decode dut_i (
    .clk           (clk),
    .rst           (rst),
    .addr_i        (addr),
    .fc_i          (fc),
    .rw_i          (rw),
    .as_n_i        (as_n),
    .map_sel_i     (map_sel),
    .wp_i          (wp),
    .boot_done_i   (boot_done),
    .prog_volt_n_i (pv_n),
    .cs_prim_n_o   (cs_prim_n),
    .cs_sec_n_o    (cs_sec_n),
    .we_n_o        (we_n),
    .ack8_n_o      (ack8_n),
    .berr_n_o      (berr_n),
    .rom_addr_o    (rom_addr),
    .vpp_prim_n_o  (vpp_n)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: pops the expected snapshot and compares it with the ports
  initial begin
    forever begin
      @(smp_ev);
      begin
        snap_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (cs_prim_n !== e.cp || cs_sec_n !== e.cs || we_n !== e.we ||
            ack8_n !== e.ack || berr_n !== e.berr ||
            (e.chk_rom && rom_addr !== e.rom)) begin
          n_bad++;
          $display("FAIL %s: actual cp=%b cs=%b we=%b ack=%b berr=%b rom=%h expected cp=%b cs=%b we=%b ack=%b berr=%b rom=%h",
                   t, cs_prim_n, cs_sec_n, we_n, ack8_n, berr_n, rom_addr,
                   e.cp, e.cs, e.we, e.ack, e.berr, e.rom);
        end
      end
    end
  end

  task automatic push(input snap_t s, input string tag);
    exp_q.push_back(s);
    tag_q.push_back(tag);
    -> smp_ev;
  endtask

  // driver: one bus access with three expected snapshots
  task automatic access(input logic [31:0] a, input logic [2:0] f, input logic r,
                        input logic w, input string tag);
    logic        hit, sec, blk, go;
    logic [19:0] ra;
    snap_t       s;
    hit = (f != 3'b111) &&
          (booted_m ? (a[31:20] == 12'hFFE) : (a[31:12] != 20'hFFD00));
    sec = map_sel | a[19];
    ra  = map_sel ? a[19:0] : {1'b0, a[18:0]};
    blk = hit && !r && w;
    go  = hit && !blk;
    @(negedge clk);
    addr = a; fc = f; rw = r; wp = w; as_n = 1'b0;
    repeat (WAIT) @(negedge clk);
    s = '{cp: !(go && !sec), cs: !(go && sec), we: !(go && !r), ack: 1'b1,
          berr: !blk, chk_rom: go, rom: ra};
    push(s, {tag, " before ack"});
    @(negedge clk);
    s.ack = !go;
    push(s, {tag, " ack due"});
    as_n = 1'b1;
    @(negedge clk);
    s = '{cp: 1'b1, cs: 1'b1, we: 1'b1, ack: 1'b1, berr: 1'b1, chk_rom: 1'b0, rom: '0};
    push(s, {tag, " released"});
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_bit("R1 cs_prim in reset", cs_prim_n, 1'b1);
    check_bit("R1 ack in reset", ack8_n, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R1 cs_sec after reset", cs_sec_n, 1'b1);
    check_bit("R1 berr after reset", berr_n, 1'b1);
    check_bit("R1 we after reset", we_n, 1'b1);

    // overlay phase
    map_sel = 1'b0;
    access(32'h0000_0000, 3'b110, 1'b1, 1'b0, "R2 overlay reset vector");
    access(32'h1234_5678, 3'b101, 1'b1, 1'b0, "R2 overlay high half");
    access(32'hFFD0_0010, 3'b101, 1'b1, 1'b0, "R2 register window");
    access(32'hFFD0_1000, 3'b101, 1'b1, 1'b0, "R2 just past register window");
    access(32'h0000_0100, 3'b111, 1'b1, 1'b0, "R7 cpu space overlay");

    // end overlay
    @(negedge clk);
    boot_done = 1'b1;
    @(negedge clk);
    boot_done = 1'b0;
    booted_m = 1'b1;
    access(32'h0000_0000, 3'b110, 1'b1, 1'b0, "R3 overlay ended");
    access(32'hFFDF_FFFF, 3'b101, 1'b1, 1'b0, "R4 below window");
    access(32'hFFF0_0000, 3'b101, 1'b1, 1'b0, "R4 above window");
    access(32'hFFE0_0000, 3'b101, 1'b1, 1'b0, "R5 primary base");
    access(32'hFFE7_FFFF, 3'b101, 1'b1, 1'b0, "R5 primary top");
    access(32'hFFE8_0000, 3'b101, 1'b1, 1'b0, "R5 secondary base");
    access(32'hFFEF_ABCD, 3'b101, 1'b1, 1'b0, "R5 secondary bit19 dropped");
    access(32'hFFE4_0000, 3'b111, 1'b1, 1'b0, "R7 cpu space window");
    access(32'hFFE1_0002, 3'b101, 1'b0, 1'b0, "R8 unprotected write");
    access(32'hFFE1_0002, 3'b101, 1'b0, 1'b1, "R9 protected write");
    access(32'hFFE9_0003, 3'b101, 1'b1, 1'b1, "R9 protected read");

    @(negedge clk);
    boot_done = 1'b1;
    @(negedge clk);
    boot_done = 1'b0;
    access(32'h0000_0004, 3'b110, 1'b1, 1'b0, "R3 second strobe");

    // single-socket mapping
    map_sel = 1'b1;
    access(32'hFFE0_0000, 3'b101, 1'b1, 1'b0, "R6 base to secondary");
    access(32'hFFEF_ABCD, 3'b101, 1'b1, 1'b0, "R6 full 1MB reach");
    access(32'hFFE4_0010, 3'b101, 1'b0, 1'b0, "R6 write secondary");

    // programming voltage
    pv_n = 1'b0;
    @(negedge clk);
    check_bit("R10 vpp blocked by map_sel", vpp_n, 1'b1);
    map_sel = 1'b0;
    @(negedge clk);
    check_bit("R10 vpp on", vpp_n, 1'b0);
    pv_n = 1'b1;
    @(negedge clk);
    check_bit("R10 vpp off", vpp_n, 1'b1);

    // reset brings the overlay back
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    booted_m = 1'b0;
    access(32'h0040_0000, 3'b110, 1'b1, 1'b0, "R3 overlay after reset");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule